// File: doc/BRIEF.md
# Device-to-Memory Block Copy Engine

This block is a single-channel direct memory access engine. It copies a run of words from a small local device buffer into system memory, so the processor does not have to move them one at a time. Software sets the engine up with three writes to I/O ports: a write to port 1 sets the first memory address, a write to port 2 sets how many words to move, and a write to port 4 starts the copy. The processor can then do other work until the engine interrupts it.

Once started, the engine asks for the system bus and waits until the bus is granted. For each word it then drives the data, the address and the memory-write command onto the bus at the same time. It holds them until memory acknowledges the write, and then steps its counters. The device-buffer index counts up from zero, the memory address counts up from the programmed start, and the word count counts down. When the count reaches zero, the engine gives up the bus and raises an interrupt. The interrupt stays high until the processor acknowledges it.

Each bus write behaves as a valid/ready transfer. The three output enables act as valid, and `mem_ack` acts as ready. While `mem_ack` is low, the engine holds the word, the address and the command unchanged. Memory may apply back-pressure for any number of cycles. The bus outputs are given as value and enable pairs. A value output reads as zero whenever its enable is low.

Top module: `dma_in_ctrl`

## Requirements
- R1: After reset, `bus_req`, `irq`, `addr_oe`, `data_oe` and `cmd_oe` are low, and `addr_out`, `data_out` and `cmd_out` are zero.
- R2: In idle, an `io_wr` with `io_port`=1 loads the memory start address from `io_wdata`. An `io_wr` with `io_port`=2 loads the word count from the low CW bits of `io_wdata`. An `io_wr` with `io_port`=4 starts a transfer. A write to any other port value changes nothing.
- R3: A start with a nonzero count raises `bus_req` one cycle later. No enable rises until `bus_gnt` has been seen high.
- R4: For word k of a transfer (k counts from 0), the bus carries `data_out` = ((k mod BUF_DEPTH)*257 XOR 16'hA5C3), truncated to DW bits. It carries `addr_out` = start+k (mod 2^AW) and `cmd_out` = 3'b010, with all three enables high together.
- R5: While `mem_ack` is low during a write, the bus values and enables hold steady. A write finishes in the cycle `mem_ack` is sampled high.
- R6: Exactly the programmed number of words is written. Two cycles after the last `mem_ack`, `bus_req` is low and `irq` is high.
- R7: `irq` stays high until `irq_ack` is sampled high. `irq` is low on the next cycle, and the engine is idle again.
- R8: A start with a word count of zero raises `irq` on the next cycle with no bus request and no bus cycle.
- R9: Port writes made while a transfer or its interrupt is pending are ignored. This covers the address, the count and start.
- R10: After a transfer the memory address register holds start+n and the word count holds zero. A new count and start without a new address continues from start+n.
- R11: Each start resets the device-buffer index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | Port write strobe from the processor |
| io_port | input | 3 | Port number of the write |
| io_wdata | input | AW (16) | Port write data |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| addr_out | output | AW (16) | Memory address value |
| addr_oe | output | 1 | Address bus enable |
| data_out | output | DW (16) | Write data value |
| data_oe | output | 1 | Data bus enable |
| cmd_out | output | 3 | Bus command value (memory write = 3'b010) |
| cmd_oe | output | 1 | Command bus enable |
| mem_ack | input | 1 | Memory write acknowledge (ready) |
| irq | output | 1 | Transfer-complete interrupt |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
The hardest case to reach is a port write that arrives in the middle of a transfer. The engine must ignore it, and the only way to see that is through the addresses and counts of later bus cycles. The stimulus stalls the first word of a chosen transfer with a long `mem_ack` delay. During the stall it writes a new address, a new count and a start command. It then checks that the remaining addresses continue unchanged. A follow-up start on its own must finish as a zero-count transfer, which shows the count register was not reloaded. Randomly chosen grant delays, acknowledge delays and lengths cover the rest.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_XFER, S_WAIT_ACK, S_STEP, S_DONE_INT
  } dma_state_e;

  localparam logic [2:0] CMD_MEM_WR = 3'b010;
  localparam logic [2:0] PORT_ADDR  = 3'd1;
  localparam logic [2:0] PORT_COUNT = 3'd2;
  localparam logic [2:0] PORT_GO    = 3'd4;
endpackage

// File: rtl/dma_up_counter.sv
module dma_up_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (load)  q <= load_val;
    else if (inc)   q <= q + 1'b1;
  end

  // R10
  load_inc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && inc));

  // R11
  clr_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/dma_down_counter.sv
module dma_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] q,
  output logic         zero,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (dec)   q <= q - 1'b1;
  end

  assign zero = (q == '0);
  assign last = (q == ONE);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero);

  // R6
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (q == $past(q) - 1'b1));
endmodule

// File: rtl/dma_dev_rom.sv
module dma_dev_rom #(
  parameter int          DW    = 16,
  parameter int          DEPTH = 16,
  parameter logic [15:0] SEED  = 16'hA5C3,
  localparam int         IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] word
);
  logic [DW-1:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign table_q[i] = DW'(i * 257) ^ DW'(SEED);
  end

  assign word = table_q[idx];
endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic wc_zero,
  input  logic wc_last,
  input  logic bus_gnt,
  input  logic mem_ack,
  input  logic irq_ack,
  output logic idle,
  output logic bus_req,
  output logic bus_en,
  output logic irq,
  output logic ba_clr,
  output logic step
);
  dma_state_e state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:     if (go) nxt = wc_zero ? S_DONE_INT : S_REQ;
      S_REQ:      if (bus_gnt) nxt = S_XFER;
      S_XFER:     nxt = mem_ack ? S_STEP : S_WAIT_ACK;
      S_WAIT_ACK: if (mem_ack) nxt = S_STEP;
      S_STEP:     nxt = wc_last ? S_DONE_INT : S_REQ;
      S_DONE_INT: if (irq_ack) nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  assign idle    = (state == S_IDLE);
  assign bus_req = (state == S_REQ) || (state == S_XFER) ||
                   (state == S_WAIT_ACK) || (state == S_STEP);
  assign bus_en  = (state == S_XFER) || (state == S_WAIT_ACK);
  assign irq     = (state == S_DONE_INT);
  assign ba_clr  = idle && go;
  assign step    = (state == S_STEP);

  // R3
  grant_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_en) |-> $past(bus_gnt));

  // R5
  step_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> $past(mem_ack));

  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_ack));

  // R6
  irq_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!bus_en && !bus_req));
endmodule

// File: rtl/dma_in_ctrl.sv
module dma_in_ctrl
  import dma_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          CW        = 8,
  parameter int          BUF_DEPTH = 16,
  parameter logic [15:0] ROM_SEED  = 16'hA5C3,
  localparam int         BW        = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic [2:0]    io_port,
  input  logic [AW-1:0] io_wdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] addr_out,
  output logic          addr_oe,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic [2:0]    cmd_out,
  output logic          cmd_oe,
  input  logic          mem_ack,
  output logic          irq,
  input  logic          irq_ack
);
  logic          idle, bus_en, ba_clr, step;
  logic          wc_zero, wc_last;
  logic          ld_addr, ld_count, go;
  logic [AW-1:0] ma_q;
  logic [CW-1:0] wc_q;
  logic [BW-1:0] ba_q;
  logic [DW-1:0] rom_word;

  assign ld_addr  = io_wr && idle && (io_port == PORT_ADDR);
  assign ld_count = io_wr && idle && (io_port == PORT_COUNT);
  assign go       = io_wr && idle && (io_port == PORT_GO);

  dma_ctrl_fsm u_fsm (
    .clk, .rst_n, .go, .wc_zero, .wc_last, .bus_gnt, .mem_ack, .irq_ack,
    .idle, .bus_req, .bus_en, .irq, .ba_clr, .step
  );

  dma_up_counter #(.W(AW)) u_mem_addr (
    .clk, .rst_n, .clr(1'b0), .load(ld_addr), .load_val(io_wdata),
    .inc(step), .q(ma_q)
  );

  dma_up_counter #(.W(BW)) u_buf_idx (
    .clk, .rst_n, .clr(ba_clr), .load(1'b0), .load_val('0),
    .inc(step), .q(ba_q)
  );

  dma_down_counter #(.W(CW)) u_word_cnt (
    .clk, .rst_n, .load(ld_count), .load_val(io_wdata[CW-1:0]),
    .dec(step), .q(wc_q), .zero(wc_zero), .last(wc_last)
  );

  dma_dev_rom #(.DW(DW), .DEPTH(BUF_DEPTH), .SEED(ROM_SEED)) u_rom (
    .idx(ba_q), .word(rom_word)
  );

  assign addr_oe  = bus_en;
  assign data_oe  = bus_en;
  assign cmd_oe   = bus_en;
  assign addr_out = bus_en ? ma_q : '0;
  assign data_out = bus_en ? rom_word : '0;
  assign cmd_out  = bus_en ? CMD_MEM_WR : 3'b000;

  // R5
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !mem_ack) |=> (data_oe && $stable(addr_out) && $stable(data_out)));

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !idle) |=> ($stable(ma_q) || $past(step)));

  // R3
  drive_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> bus_req);
endmodule

// File: tb/dma_in_ctrl_tb.sv
module dma_in_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_DEPTH  = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0;
  logic [2:0]  io_port = 0;
  logic [15:0] io_wdata = 0;
  logic        bus_req, bus_gnt = 0;
  logic [15:0] addr_out, data_out;
  logic        addr_oe, data_oe, cmd_oe;
  logic [2:0]  cmd_out;
  logic        mem_ack = 0;
  logic        irq, irq_ack = 0;

  int checks = 0;
  int errors = 0;
  logic [15:0] cur_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_in_ctrl u_dut (
    .clk, .rst_n, .io_wr, .io_port, .io_wdata, .bus_req, .bus_gnt,
    .addr_out, .addr_oe, .data_out, .data_oe, .cmd_out, .cmd_oe,
    .mem_ack, .irq, .irq_ack
  );

  function automatic logic [15:0] exp_word(int k);
    return 16'((k % BUF_DEPTH) * 257) ^ 16'hA5C3;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic port_wr(logic [2:0] p, logic [15:0] d);
    io_wr = 1; io_port = p; io_wdata = d;
    @(negedge clk);
    io_wr = 0; io_port = 0; io_wdata = 0;
  endtask

  task automatic finish_irq(int hold);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(irq == 1, "R7 irq held", irq, 1);
    end
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    chk(irq == 0, "R7 irq released", irq, 0);
  endtask

  // Run n words starting at cur_addr; meddle issues port writes during a stall.
  task automatic transfer(int n, bit meddle);
    int gdly, adly, wait_cnt;
    logic [15:0] a0, d0;
    port_wr(3'd2, 16'(n));
    port_wr(3'd4, 16'h0);
    chk(bus_req == 1, "R3 bus_req after start", bus_req, 1);
    gdly = $urandom_range(0, 4);
    for (int i = 0; i < gdly; i++) begin
      chk(data_oe == 0 && addr_oe == 0, "R3 no drive before grant", data_oe, 0);
      @(negedge clk);
    end
    bus_gnt = 1;
    for (int k = 0; k < n; k++) begin
      wait_cnt = 0;
      while (!data_oe && wait_cnt < 20) begin
        @(negedge clk); wait_cnt++;
      end
      chk(data_oe && addr_oe && cmd_oe, "R4 enables together",
          {data_oe, addr_oe, cmd_oe}, 3'b111);
      chk(data_out == exp_word(k), "R4 data word", data_out, exp_word(k));
      chk(addr_out == cur_addr + 16'(k), "R4 address", addr_out, cur_addr + 16'(k));
      chk(cmd_out == 3'b010, "R4 command", cmd_out, 3'b010);
      a0 = addr_out; d0 = data_out;
      adly = (meddle && k == 0) ? 3 : $urandom_range(0, 3);
      for (int i = 0; i < adly; i++) begin
        if (meddle && k == 0) begin
          io_wr = 1; io_port = (i == 0) ? 3'd1 : (i == 1) ? 3'd2 : 3'd4;
          io_wdata = 16'h7777;
        end
        @(negedge clk);
        io_wr = 0; io_port = 0; io_wdata = 0;
        chk(data_oe && addr_out == a0 && data_out == d0, "R5 hold under stall",
            addr_out, a0);
      end
      mem_ack = 1;
      @(negedge clk);
      mem_ack = 0;
      if (k == n-1) begin
        @(negedge clk);
        chk(irq == 1 && bus_req == 0, "R6 irq and release after last word",
            {irq, bus_req}, 2'b10);
      end
    end
    bus_gnt = 0;
    finish_irq($urandom_range(0, 3));
    cur_addr = cur_addr + 16'(n);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd1234);
    cur_addr = 16'h0;
    #(CLK_PERIOD*2 + 2);
    @(negedge clk);
    // R1 reset state
    chk(!bus_req && !irq && !addr_oe && !data_oe && !cmd_oe, "R1 reset controls",
        {bus_req, irq, addr_oe, data_oe, cmd_oe}, 0);
    chk(addr_out == 0 && data_out == 0 && cmd_out == 0, "R1 reset values", addr_out, 0);
    rst_n = 1;
    @(negedge clk);

    // R8 zero count
    port_wr(3'd4, 16'h0);
    chk(irq == 1 && bus_req == 0, "R8 zero-count irq", {irq, bus_req}, 2'b10);
    finish_irq(2);

    // R2 unknown port ignored: port 3 write must not start anything
    port_wr(3'd3, 16'h0005);
    chk(bus_req == 0 && irq == 0, "R2 other port ignored", {bus_req, irq}, 0);

    // R2 directed: address load, then R11 buffer restarts each time
    cur_addr = 16'h1000;
    port_wr(3'd1, cur_addr);
    transfer(3, 0);
    transfer(2, 0);          // R10: continues at 0x1003, R11: words from index 0

    // R9 writes while busy
    transfer(4, 1);
    port_wr(3'd4, 16'h0);    // count still zero -> R9/R10
    chk(irq == 1 && bus_req == 0, "R9 busy count write ignored", {irq, bus_req}, 2'b10);
    finish_irq(0);

    // address wrap and buffer wrap
    cur_addr = 16'hFFFE;
    port_wr(3'd1, cur_addr);
    transfer(BUF_DEPTH + 2, 0);

    // random transfers
    for (int t = 0; t < 8; t++) begin
      cur_addr = 16'($urandom);
      port_wr(3'd1, cur_addr);
      transfer($urandom_range(1, 20), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule